// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between a protocol controller's transmit-data line and the enable of a single-wire bus driver. A low transmit level asks for the dominant bus state, a high level leaves the bus recessive. The guard forwards that request to the driver enable. It also counts how long an unbroken dominant request has lasted, in microsecond ticks. When the count reaches a programmable limit, it turns the driver off and raises a sticky timeout flag. This keeps a stuck transmitter from blocking the whole bus. After a timeout, the driver comes back only on the next low-to-high transition of the transmit line. There is no timer-based release and no extra wait.

While the sleep indication is high, the driver is never enabled. The same limit applies in every active mode, so the block needs only the sleep indication and not the full mode code. The transmit line passes through a two-flop synchronizer, which resets to the recessive level. A line that has not yet been driven therefore reads as recessive.

The control is a four-state machine:
- RECESSIVE: idle, driver off.
- DOMINANT: driving.
- TRIPPED: timed out, waiting for a rising edge on the transmit line.
- BLOCKED: sleep, or waiting after sleep for the transmit line to go high.

The transitions are:
- RECESSIVE to DOMINANT when the synchronized transmit level is low.
- DOMINANT to RECESSIVE when it goes high.
- DOMINANT to TRIPPED when the tick count reaches the limit.
- TRIPPED to RECESSIVE when the transmit level goes high.
- Any state to BLOCKED while sleep is high.
- BLOCKED to RECESSIVE once sleep is low and the transmit level is high.

Top module: `txd_timeout_guard`

## Requirements
- R1: A low on `txd_in` makes `drv_dom` high after exactly three rising clock edges (two synchronizer flops and the state register). A return to high makes `drv_dom` low after the same three edges, provided no timeout has occurred.
- R2: While `rst_n` is low, `drv_dom` and `tmo_flag` are 0 whatever `txd_in` does. The synchronizer starts at the recessive level 1.
- R3: A continuous dominant request trips at the first edge after the tick count has reached `TIMEOUT_US`. With a tick on every cycle, `drv_dom` stays high for exactly `TIMEOUT_US+1` cycles, and `tmo_flag` rises on the same edge that drops `drv_dom`.
- R4: Only cycles with `us_tick` high advance the timeout count. With `us_tick` held low, a dominant request never trips.
- R5: After a trip, `drv_dom` stays low and `tmo_flag` stays high for as long as `txd_in` stays low. A rising `txd_in` clears `tmo_flag` three edges later, and the next low drives again with the R1 latency.
- R6: `drv_dom` is low in every cycle in which `sleep_en` is high, including the very cycle it rises. A low `txd_in` held during sleep never sets `tmo_flag`.
- R7: When sleep ends while `txd_in` is low, `drv_dom` stays low until `txd_in` has been seen high. After that, a low drives normally.
- R8: When a dominant request is released exactly on the trip edge (a low held for `TIMEOUT_US+1` cycles with a tick every cycle), the release wins and `tmo_flag` stays 0.
- R9: Once set, `tmo_flag` stays set through sleep and its exit. It clears only on a rising edge of the synchronized transmit level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_in | input | 1 | Transmit data from the controller; 0 requests dominant |
| sleep_en | input | 1 | High while the transceiver is in sleep mode |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| drv_dom | output | 1 | Driver enable; 1 drives the bus dominant |
| tmo_flag | output | 1 | Sticky dominant-timeout indication |

## Verification
Every change on `txd_in` reaches `drv_dom` and the flag clear on the third rising edge, and a sleep request reaches `drv_dom` in the same cycle. The bench drives inputs one time unit after a rising edge and samples on the falling edge, counting edges from the change. A sweep over every pulse length from 1 to `TIMEOUT_US+6` (limit 8, a tick each cycle) checks the predicted count of high `drv_dom` samples, min(L, limit+1), and whether a trip happened, L >= limit+2. That includes the tie at L = limit+1. The gated-tick case predicts the trip exactly limit+1 edges after ticks resume.

// File: rtl/txg_pkg.sv
package txg_pkg;
    typedef enum logic [1:0] {
        ST_RECESSIVE = 2'd0,
        ST_DOMINANT  = 2'd1,
        ST_TRIPPED   = 2'd2,
        ST_BLOCKED   = 2'd3
    } guard_state_t;
endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/txg_dom_timer.sv
module txg_dom_timer #(
    parameter int LIMIT = 17000,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    output logic          expired,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     count <= '0;
        else if (!run)                  count <= '0;
        else if (tick && count != LIM_C) count <= count + 1'b1;
    end

    assign expired = (count == LIM_C);
endmodule

// File: rtl/txd_timeout_guard.sv
module txd_timeout_guard
    import txg_pkg::*;
#(
    parameter int TIMEOUT_US  = 17000,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(TIMEOUT_US + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_in,
    input  logic sleep_en,
    input  logic us_tick,
    output logic drv_dom,
    output logic tmo_flag
);
    guard_state_t state, state_nx;
    logic          tx_s;
    logic          tx_d;
    logic          tx_rise;
    logic          expired;
    logic [CW-1:0] tmr_cnt;
    logic          timer_run;

    txg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (txd_in),
        .q     (tx_s)
    );

    txg_dom_timer #(.LIMIT(TIMEOUT_US)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .tick    (us_tick),
        .expired (expired),
        .count   (tmr_cnt)
    );

    assign timer_run = (state == ST_DOMINANT);
    assign tx_rise   = tx_s && !tx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RECESSIVE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (sleep_en) begin
            state_nx = ST_BLOCKED;
        end else begin
            unique case (state)
                ST_RECESSIVE: if (!tx_s) state_nx = ST_DOMINANT;
                ST_DOMINANT: begin
                    if (tx_s)         state_nx = ST_RECESSIVE;
                    else if (expired) state_nx = ST_TRIPPED;
                end
                ST_TRIPPED:   if (tx_s) state_nx = ST_RECESSIVE;
                ST_BLOCKED:   if (tx_s) state_nx = ST_RECESSIVE;
            endcase
        end
    end

    // edge history and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_d     <= 1'b1;
            tmo_flag <= 1'b0;
        end else begin
            tx_d <= tx_s;
            if (tx_rise)
                tmo_flag <= 1'b0;
            else if (state == ST_DOMINANT && state_nx == ST_TRIPPED)
                tmo_flag <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        drv_dom = 1'b0;
        unique case (state)
            ST_DOMINANT:  drv_dom = !sleep_en;
            ST_RECESSIVE,
            ST_TRIPPED,
            ST_BLOCKED:   drv_dom = 1'b0;
        endcase
    end
endmodule

// File: rtl/txg_guard_chk.sv
module txg_guard_chk #(
    parameter int LIMIT = 17000,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep_en,
    input logic          drv_dom,
    input logic          tmo_flag,
    input logic          tx_sync,
    input logic          tx_prev,
    input logic [CW-1:0] cnt
);
    AST_SLEEP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_en |-> !drv_dom);                                        // R6
    AST_DRIVE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_dom) |-> !$past(tx_sync));                           // R1
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT));                                            // R3
    AST_TRIP_DROPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> !drv_dom && $past(drv_dom));               // R3
    AST_FLAG_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |-> !drv_dom);                                        // R5
    AST_FLAG_CLEAR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmo_flag) |-> $past(tx_sync) && !$past(tx_prev));        // R9
endmodule

bind txd_timeout_guard txg_guard_chk #(.LIMIT(TIMEOUT_US)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_en (sleep_en),
    .drv_dom  (drv_dom),
    .tmo_flag (tmo_flag),
    .tx_sync  (tx_s),
    .tx_prev  (tx_d),
    .cnt      (tmr_cnt)
);

// File: tb/txd_timeout_guard_test.sv
module txd_timeout_guard_test;
    localparam int T = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd_in = 1'b1;
    logic sleep_en = 1'b0;
    logic us_tick = 1'b1;
    logic drv_dom, tmo_flag;

    int checks = 0;
    int errors = 0;
    int hi_cnt = 0;
    logic flag_seen = 1'b0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    txd_timeout_guard #(.TIMEOUT_US(T)) uut (
        .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .sleep_en(sleep_en),
        .us_tick(us_tick), .drv_dom(drv_dom), .tmo_flag(tmo_flag)
    );

    always @(negedge clk) begin
        if (drv_dom)  hi_cnt = hi_cnt + 1;
        if (tmo_flag) flag_seen = 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sample;
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R2 reset with txd low
        txd_in = 1'b0;
        edges(3);
        sample;
        chk("R2 drv in reset", drv_dom, 0);
        chk("R2 flag in reset", tmo_flag, 0);
        txd_in = 1'b1;
        edges(2);
        rst_n = 1'b1;
        edges(4);
        sample;
        chk("R2 drv after reset", drv_dom, 0);

        // R1 latency
        edges(1);
        txd_in = 1'b0;
        edges(2); sample;
        chk("R1 not yet dominant", drv_dom, 0);
        edges(1); sample;
        chk("R1 dominant on 3rd edge", drv_dom, 1);
        edges(1);
        txd_in = 1'b1;
        edges(2); sample;
        chk("R1 still dominant", drv_dom, 1);
        edges(1); sample;
        chk("R1 released on 3rd edge", drv_dom, 0);
        edges(4);

        // R3 / R8 sweep of pulse lengths
        for (int len = 1; len <= T + 6; len++) begin
            hi_cnt = 0;
            flag_seen = 1'b0;
            txd_in = 1'b0;
            edges(len);
            chk($sformatf("R3 flag before release L=%0d", len), tmo_flag, (len >= T + 4) ? 1 : 0);
            txd_in = 1'b1;
            edges(5);
            sample;
            chk($sformatf("R3 dominant cycles L=%0d", len), hi_cnt, (len < T + 1) ? len : T + 1);
            chk($sformatf("R3 R8 trip seen L=%0d", len), flag_seen, (len >= T + 2) ? 1 : 0);
            chk($sformatf("R5 flag cleared L=%0d", len), tmo_flag, 0);
            edges(1);
        end

        // R4 tick gating
        us_tick = 1'b0;
        txd_in = 1'b0;
        edges(4 * T);
        sample;
        chk("R4 no trip without ticks drv", drv_dom, 1);
        chk("R4 no trip without ticks flag", tmo_flag, 0);
        edges(1);
        us_tick = 1'b1;
        edges(T); sample;
        chk("R4 still driving before trip", drv_dom, 1);
        edges(1); sample;
        chk("R4 tripped after ticks", drv_dom, 0);
        chk("R3 flag set at trip", tmo_flag, 1);

        // R5 held low after trip, then resume
        edges(3 * T); sample;
        chk("R5 stays off while low", drv_dom, 0);
        chk("R5 flag stays set", tmo_flag, 1);
        edges(1);
        txd_in = 1'b1;
        edges(2); sample;
        chk("R5 flag before clear", tmo_flag, 1);
        edges(1); sample;
        chk("R5 flag clears on 3rd edge", tmo_flag, 0);
        edges(1);
        txd_in = 1'b0;
        edges(3); sample;
        chk("R5 resume drive latency", drv_dom, 1);

        // R6 sleep
        edges(1);
        sleep_en = 1'b1;
        sample;
        chk("R6 drive off same cycle", drv_dom, 0);
        hi_cnt = 0;
        flag_seen = 1'b0;
        edges(3 * T); sample;
        chk("R6 no drive in sleep", hi_cnt, 0);
        chk("R6 no flag in sleep", flag_seen, 0);

        // R7 exit with txd low
        edges(1);
        sleep_en = 1'b0;
        hi_cnt = 0;
        edges(6); sample;
        chk("R7 blocked after sleep low", hi_cnt, 0);
        edges(1);
        txd_in = 1'b1;
        edges(4);
        txd_in = 1'b0;
        edges(3); sample;
        chk("R7 drives after seeing high", drv_dom, 1);

        // R9 flag through sleep
        edges(T + 2); sample;
        chk("R9 tripped flag", tmo_flag, 1);
        edges(1);
        sleep_en = 1'b1;
        edges(5); sample;
        chk("R9 flag kept in sleep", tmo_flag, 1);
        edges(1);
        sleep_en = 1'b0;
        edges(5); sample;
        chk("R9 flag kept after sleep", tmo_flag, 1);
        edges(1);
        txd_in = 1'b1;
        edges(4); sample;
        chk("R9 flag cleared by rise", tmo_flag, 0);
        chk("R9 drive off", drv_dom, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule